// File: doc/BRIEF.md
# Program Memory Blank-Check Scanner

This block runs a blank check over a program memory that has a simple synchronous read port with one cycle of latency. A start strobe loads an inclusive address range. The scanner then walks that range in ascending order and reads one word per cycle. It compares each returned word, one cycle after the read, against the all-ones erased value. Any word with a zero bit marks the memory as programmed. The scan then stops at once and returns NOT BLANK, which also raises an erase-required flag. If every word checked is all ones, the verdict is BLANK.

Some addresses are never read and never affect the verdict. The first is a fixed device-ID window that cannot be erased, at 0xFF0000 to 0xFF0002. The others are a parameterized set of unimplemented windows. When the scan address lands inside a skipped window, the scanner spends one cycle with no read and jumps to the word just past that window. A one-cycle done pulse ends every scan. The verdict outputs keep their value until the next scan completes.

Top module: `blank_scan`

## Requirements
- R1: While reset is held and right after it, busy, done, rdEn, isBlank and eraseReq are all 0.
- R2: During a scan, rdEn is high with rdAddr set to each checked address in ascending order from startAddr to endAddr inclusive. Consecutive read cycles carry consecutive addresses, and the word read in one cycle is judged in the next cycle.
- R3: Addresses 0xFF0000 through 0xFF0002 are never read, and the contents there never change the verdict.
- R4: Addresses inside each unimplemented window are never read, and the contents there never change the verdict. The default windows are 0x000040–0x00005F and 0x000080–0x0000BF. Reaching a window costs one cycle with rdEn low, after which the scan resumes at the window's last address plus one.
- R5: A word is blank only when all WORD_W bits are 1. A BLANK verdict sets isBlank=1 and eraseReq=0. A NOT BLANK verdict sets isBlank=0 and eraseReq=1. Both outputs hold until the next scan completes.
- R6: done is high for exactly one cycle, in the cycle after the final decision, and busy is low in that same cycle.
- R7: In the cycle that a non-blank word's data returns, the scan decides NOT BLANK, and it issues no read after that cycle.
- R8: busy goes high in the cycle after an accepted start. A start strobe while busy is ignored, and the range in use is not changed.
- R9: If startAddr is greater than endAddr, the scan makes no read and reports BLANK.
- R10: A range that ends at the top address 0xFFFFFF completes without wrapping to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a scan when the block is idle |
| startAddr | input | ADDR_W | First address of the range |
| endAddr | input | ADDR_W | Last address of the range, inclusive |
| rdData | input | WORD_W | Read data from the memory, valid one cycle after rdEn |
| rdAddr | output | ADDR_W | Memory read address |
| rdEn | output | 1 | Memory read enable |
| busy | output | 1 | High while a scan is in progress |
| done | output | 1 | One-cycle completion pulse |
| isBlank | output | 1 | Verdict of the last scan: 1 means BLANK |
| eraseReq | output | 1 | Verdict of the last scan: 1 means NOT BLANK, so an erase is needed |

## Verification
The hardest cases to reach are those where the read pipeline meets a boundary in the same cycle. These include a failing word whose data returns in the cycle where the next address falls in a skipped window, and a range that ends on the last address of the whole space. The stimulus places programmed words inside the ID window and inside both unimplemented windows. It scans ranges that straddle each window and the top of the address space. It also sends a second start strobe in the middle of a scan, with a range that would fail if that strobe were taken. A behavioural model follows the scan cycle by cycle and predicts rdEn, rdAddr, busy, done and the verdict on every clock.

// File: rtl/blank_scan_pkg.sv
package blank_scan_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic scan;    // scan in progress
    logic load;    // latch a new range
    logic step;    // issue a read and advance
    logic jump;    // hop over an excluded window
    logic finish;  // scan is ending this cycle
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic exhausted; // current address past the end of the range
    logic excluded;  // current address inside a skipped window
    logic failSeen;  // returned word has at least one zero bit
  } dpStatus_t;

endpackage

// File: rtl/blank_scan_dp.sv
module blank_scan_dp
  import blank_scan_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int WORD_W    = 24,
  parameter int NUM_HOLES = 2,
  parameter logic [NUM_HOLES*ADDR_W-1:0] HOLE_LO = {24'h000080, 24'h000040},
  parameter logic [NUM_HOLES*ADDR_W-1:0] HOLE_HI = {24'h0000BF, 24'h00005F},
  parameter logic [ADDR_W-1:0] ID_LO = 24'hFF0000,
  parameter logic [ADDR_W-1:0] ID_HI = 24'hFF0002
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [WORD_W-1:0] rdData,
  output dpStatus_t         stat,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdEn
);

  localparam int CW = ADDR_W + 1;      // one spare bit so the top address never wraps
  localparam int NW = NUM_HOLES + 1;   // ID window plus unimplemented windows

  logic [CW-1:0]     cur;
  logic [ADDR_W-1:0] last;
  logic              pend;

  logic [ADDR_W-1:0] winLo [NW];
  logic [ADDR_W-1:0] winHi [NW];
  logic [NW-1:0]     hit;
  logic [CW-1:0]     jumpTo;

  assign winLo[0] = ID_LO;
  assign winHi[0] = ID_HI;

  genvar g;
  generate
    for (g = 0; g < NUM_HOLES; g++) begin : gHole
      assign winLo[g+1] = HOLE_LO[g*ADDR_W +: ADDR_W];
      assign winHi[g+1] = HOLE_HI[g*ADDR_W +: ADDR_W];
    end
    for (g = 0; g < NW; g++) begin : gHit
      assign hit[g] = (cur >= {1'b0, winLo[g]}) && (cur <= {1'b0, winHi[g]});
    end
  endgenerate

  // lowest-index matching window wins
  always_comb begin
    jumpTo = cur + CW'(1);
    for (int w = NW - 1; w >= 0; w--) begin
      if (hit[w]) jumpTo = {1'b0, winHi[w]} + CW'(1);
    end
  end

  assign stat.exhausted = cur > {1'b0, last};
  assign stat.excluded  = |hit;
  assign stat.failSeen  = pend && (rdData != {WORD_W{1'b1}});

  assign rdEn   = strb.scan && !stat.exhausted && !stat.excluded;
  assign rdAddr = cur[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur  <= '0;
      last <= '0;
      pend <= 1'b0;
    end else if (strb.load) begin
      cur  <= {1'b0, startAddr};
      last <= endAddr;
      pend <= 1'b0;
    end else if (strb.step) begin
      cur  <= cur + CW'(1);
      pend <= 1'b1;
    end else if (strb.jump) begin
      cur  <= jumpTo;
      pend <= 1'b0;
    end else if (strb.finish) begin
      pend <= 1'b0;
    end
  end

  assert_read_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |-> (rdAddr == $past(rdAddr) + ADDR_W'(1)));

  assert_skip_id_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !((rdAddr >= ID_LO) && (rdAddr <= ID_HI)));

  assert_range_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scan && $past(strb.scan)) |-> $stable(last));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scan && $past(strb.scan) && !$past(strb.load)) |-> (cur >= $past(cur)));

endmodule

// File: rtl/blank_scan_ctrl.sv
module blank_scan_ctrl
  import blank_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  dpStatus_t  stat,
  output ctlStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       isBlank,
  output logic       eraseReq
);

  scanState_t state;

  always_comb begin
    strb      = '0;
    strb.scan = (state == ST_SCAN);
    if (state == ST_IDLE) begin
      strb.load = startPulse;
    end else if (stat.failSeen || stat.exhausted) begin
      strb.finish = 1'b1;
    end else if (stat.excluded) begin
      strb.jump = 1'b1;
    end else begin
      strb.step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      isBlank  <= 1'b0;
      eraseReq <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        state <= ST_SCAN;
      end else if (strb.finish) begin
        state    <= ST_IDLE;
        done     <= 1'b1;
        isBlank  <= !stat.failSeen;
        eraseReq <= stat.failSeen;
      end
    end
  end

  assign busy = (state == ST_SCAN);

  assert_verdict_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (isBlank != eraseReq));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_early_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stat.failSeen) |=> (done && eraseReq && !busy));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy);

endmodule

// File: rtl/blank_scan.sv
module blank_scan
  import blank_scan_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int WORD_W    = 24,
  parameter int NUM_HOLES = 2,
  parameter logic [NUM_HOLES*ADDR_W-1:0] HOLE_LO = {24'h000080, 24'h000040},
  parameter logic [NUM_HOLES*ADDR_W-1:0] HOLE_HI = {24'h0000BF, 24'h00005F},
  parameter logic [ADDR_W-1:0] ID_LO = 24'hFF0000,
  parameter logic [ADDR_W-1:0] ID_HI = 24'hFF0002
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdEn,
  output logic              busy,
  output logic              done,
  output logic              isBlank,
  output logic              eraseReq
);

  ctlStrobe_t strb;
  dpStatus_t  stat;

  blank_scan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .stat       (stat),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .isBlank    (isBlank),
    .eraseReq   (eraseReq)
  );

  blank_scan_dp #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .NUM_HOLES (NUM_HOLES),
    .HOLE_LO   (HOLE_LO),
    .HOLE_HI   (HOLE_HI),
    .ID_LO     (ID_LO),
    .ID_HI     (ID_HI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .rdData    (rdData),
    .stat      (stat),
    .rdAddr    (rdAddr),
    .rdEn      (rdEn)
  );

endmodule

// File: tb/sim_blank_scan.sv
module sim_blank_scan;

  localparam int AW = 24;
  localparam int WW = 24;
  localparam logic [WW-1:0] ONES = {WW{1'b1}};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] endAddr = '0;
  logic [WW-1:0] rdData = '0;
  logic [AW-1:0] rdAddr;
  logic          rdEn, busy, done, isBlank, eraseReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [WW-1:0] prog [int];   // programmed words; everything else reads erased

  always #10 clk = ~clk;       // 50 MHz

  blank_scan u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .startAddr(startAddr), .endAddr(endAddr), .rdData(rdData),
    .rdAddr(rdAddr), .rdEn(rdEn), .busy(busy), .done(done),
    .isBlank(isBlank), .eraseReq(eraseReq)
  );

  function automatic logic [WW-1:0] memWord(input longint a);
    if (prog.exists(int'(a))) return prog[int'(a)];
    return ONES;
  endfunction

  // memory: one cycle read latency
  always @(posedge clk) if (rdEn) rdData <= memWord(rdAddr);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit     mBusy, mPend, mDone, mBlank, mErase;
  longint mCur, mLast, mPendAddr;

  function automatic bit inWin(input longint a, output longint nxt);
    longint lo [3] = '{64'hFF0000, 64'h40, 64'h80};
    longint hi [3] = '{64'hFF0002, 64'h5F, 64'hBF};
    for (int k = 0; k < 3; k++)
      if (a >= lo[k] && a <= hi[k]) begin nxt = hi[k] + 1; return 1'b1; end
    nxt = a + 1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    longint nx;
    bit fail;
    if (!rstN) begin
      mBusy = 0; mPend = 0; mDone = 0; mBlank = 0; mErase = 0;
      mCur = 0; mLast = 0; mPendAddr = 0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (startPulse) begin
          mBusy = 1; mCur = startAddr; mLast = endAddr; mPend = 0;
        end
      end else begin
        fail = mPend && (memWord(mPendAddr) != ONES);
        if (fail || mCur > mLast) begin
          mBusy = 0; mDone = 1; mBlank = !fail; mErase = fail; mPend = 0;
        end else if (inWin(mCur, nx)) begin
          mCur = nx; mPend = 0;
        end else begin
          mPendAddr = mCur; mPend = 1; mCur = mCur + 1;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    longint nx;
    bit expEn;
    if (rstN) begin
      expEn = mBusy && (mCur <= mLast) && !inWin(mCur, nx);
      chk(rdEn == expEn, "R2 R3 R4 R7 rdEn", rdEn, expEn);
      if (expEn) chk(rdAddr == mCur[AW-1:0], "R2 R10 rdAddr", rdAddr, mCur);
      chk(busy == mBusy, "R8 busy", busy, mBusy);
      chk(done == mDone, "R6 done", done, mDone);
      chk(isBlank == mBlank, "R5 isBlank", isBlank, mBlank);
      chk(eraseReq == mErase, "R5 eraseReq", eraseReq, mErase);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runScan(input logic [AW-1:0] sa, input logic [AW-1:0] ea,
                         input bit expBlank, input string req,
                         input int midAt, input logic [AW-1:0] altS, input logic [AW-1:0] altE);
    int n = 0;
    @(negedge clk);
    startAddr = sa; endAddr = ea; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    while (!done && n < 20000) begin
      if (midAt > 0 && n == midAt) begin
        startAddr = altS; endAddr = altE; startPulse = 1'b1;
      end else begin
        startPulse = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    startPulse = 1'b0;
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(isBlank == expBlank, {req, " verdict isBlank"}, isBlank, expBlank);
    chk(eraseReq == !expBlank, {req, " verdict eraseReq"}, eraseReq, !expBlank);
    chk(busy == 1'b0, "R6 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    chk(isBlank == expBlank, "R5 verdict held", isBlank, expBlank);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy in reset", busy, 0);
    chk(done == 0, "R1 done in reset", done, 0);
    chk(rdEn == 0, "R1 rdEn in reset", rdEn, 0);
    chk(isBlank == 0, "R1 isBlank in reset", isBlank, 0);
    chk(eraseReq == 0, "R1 eraseReq in reset", eraseReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && rdEn == 0, "R1 idle after reset", {busy, done, rdEn}, 0);

    // plain blank range
    runScan(24'h000010, 24'h000030, 1'b1, "R2", 0, '0, '0);
    // top bit zero in one word
    prog[24'h20] = 24'h7FFFFF;
    runScan(24'h000010, 24'h000030, 1'b0, "R7", 0, '0, '0);
    // failing word on the first address
    runScan(24'h000020, 24'h000025, 1'b0, "R5", 0, '0, '0);
    prog.delete(24'h20);
    // programmed words inside unimplemented windows
    prog[24'h50] = 24'h000000;
    prog[24'h90] = 24'h123456;
    runScan(24'h000030, 24'h0000D0, 1'b1, "R4", 0, '0, '0);
    // fail just before a window
    prog[24'h3F] = 24'hFFFFFE;
    runScan(24'h000030, 24'h0000D0, 1'b0, "R4 R5", 0, '0, '0);
    prog.delete(24'h3F);
    // programmed word inside the ID window
    prog[24'hFF0001] = 24'h000000;
    runScan(24'hFEFFFC, 24'hFF0006, 1'b1, "R3", 0, '0, '0);
    // fail right after the ID window
    prog[24'hFF0003] = 24'hFFFEFF;
    runScan(24'hFEFFFC, 24'hFF0006, 1'b0, "R3 R7", 0, '0, '0);
    // top of the address space
    runScan(24'hFFFFF0, 24'hFFFFFF, 1'b1, "R10", 0, '0, '0);
    prog[24'hFFFFFF] = 24'hFFFFFE;
    runScan(24'hFFFFF0, 24'hFFFFFF, 1'b0, "R10", 0, '0, '0);
    // empty range
    runScan(24'h000100, 24'h000050, 1'b1, "R9", 0, '0, '0);
    // start while busy is ignored
    prog[24'h20] = 24'h000000;
    runScan(24'h000100, 24'h0001FF, 1'b1, "R8", 20, 24'h000020, 24'h000020);
    // back-to-back after the ignored start: the bad word is found
    runScan(24'h000020, 24'h000020, 1'b0, "R5", 0, '0, '0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule